// File: doc/BRIEF.md
# Dual Reference Strobe Divider with Routing

This block turns one reference clock into two strobes that pace a pair of phase comparators. A programmable main divider produces the base strobe (point A). Two fixed post-dividers, both counting point-A strobes, give a strobe at one quarter (point B) and one twenty-fifth (point C) of the point-A rate. A second, wider programmable divider (point D) can be switched on when neither post-divider gives the rate a loop needs.

Two steering outputs carry the strobes. The first output, `fr1Strobe`, takes A, B or C according to a two-bit select code. The second output, `fr2Strobe`, takes C when the auxiliary divider is off and D when it is on. A power-down input stops both programmable dividers and holds them at their reload point. A separate output clock runs at one third or one quarter of the reference rate. Every setting arrives on a parallel input and takes effect at once. A strobe is high for exactly one reference cycle and is registered once before it reaches its port.

Top module: `refDivRoute`

## Requirements
- R1: With select code 2'b01, `fr1Strobe` pulses high for one cycle once every N reference cycles, where N = `mainRatio` (16 to 4095). After reset is released, or after power-down is released, the first pulse is seen after exactly N rising edges.
- R2: A ratio value below 16 on `mainRatio` or on `auxRatio` is treated as 16, and no strobe is ever high on two cycles in a row.
- R3: With select code 2'b10, `fr1Strobe` pulses once every 4·N cycles.
- R4: With select code 2'b11 and `auxEnable` = 1, `fr1Strobe` pulses once every 25·N cycles.
- R5: Select code 2'b00 holds `fr1Strobe` low. Select code 2'b11 holds it low when `auxEnable` = 0.
- R6: With `auxEnable` = 0, `fr2Strobe` pulses once every 25·N cycles, and any value of `auxRatio` has no effect on it.
- R7: With `auxEnable` = 1, `fr2Strobe` pulses once every M cycles, where M = `auxRatio` (16 to 16383).
- R8: While `refPowerDown` = 1, both strobe outputs stay low, and both programmable dividers restart from their reload point when power-down is released.
- R9: `mcuClk` has a period of 4 cycles and is high for 2 of them when `clkOutDiv4` = 1. When `clkOutDiv4` = 0 its period is 3 cycles and it is high for 1 of them.
- R10: While reset is asserted, `fr1Strobe`, `fr2Strobe` and `mcuClk` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mainRatio | input | 12 | Main divider ratio N |
| auxRatio | input | 14 | Auxiliary divider ratio M |
| auxEnable | input | 1 | 1 runs the auxiliary divider and routes it to fr2Strobe |
| selCode | input | 2 | fr1Strobe source: 00 off, 01 A, 10 B, 11 C (C only when auxEnable = 1) |
| refPowerDown | input | 1 | 1 halts both programmable dividers |
| clkOutDiv4 | input | 1 | 1 divides mcuClk by 4, 0 divides it by 3 |
| fr1Strobe | output | 1 | First reference strobe |
| fr2Strobe | output | 1 | Second reference strobe |
| mcuClk | output | 1 | Divided output clock |

## Verification
A main count that drifts shows up as a wrong interval between strobes within one period of the selected output. That is N cycles on point A, and 4·N or 25·N cycles on the post-divided points. A post-divider phase that is not cleared during power-down shows up as a wrong latency to the first strobe after release. A routing fault shows up on the very next strobe, either as a strobe where none should appear or as an interval from the wrong point. For these reasons the bench measures intervals between strobes, pulse widths and the latency to the first strobe after a release, and does not only count pulses.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // strobes produced by the datapath, one per routing point
  typedef struct packed {
    logic tickA;
    logic tickB;
    logic tickC;
    logic tickD;
  } refTicks_t;

  // run enables handed from control to datapath
  typedef struct packed {
    logic runMain;
    logic runAux;
  } refRun_t;

  typedef enum logic [1:0] {
    SEL_OFF = 2'b00,
    SEL_A   = 2'b01,
    SEL_B   = 2'b10,
    SEL_C   = 2'b11
  } fr1Sel_e;

endpackage

// File: rtl/progDivider.sv
module progDivider #(
  parameter int WIDTH     = 12,
  parameter int MIN_RATIO = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [WIDTH-1:0] ratio,
  output logic             tick
);
  localparam logic [WIDTH-1:0] MinVal = WIDTH'(MIN_RATIO);

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] limit;
  logic             terminal;

  always_comb begin
    limit    = (ratio < MinVal) ? MinVal : ratio;
    terminal = (cnt >= (limit - WIDTH'(1)));
    tick     = run && terminal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (terminal)  cnt <= '0;
    else                cnt <= cnt + WIDTH'(1);
  end

  AST_PULSE_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R2

endmodule

// File: rtl/fixedDivider.sv
module fixedDivider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic advance,
  output logic tick
);
  localparam int CntW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CntW-1:0] LastVal = CntW'(DIV - 1);

  logic [CntW-1:0] cnt;

  always_comb tick = advance && (cnt == LastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= (cnt == LastVal) ? '0 : cnt + CntW'(1);
  end

endmodule

// File: rtl/refDatapath.sv
module refDatapath
  import refdiv_pkg::*;
#(
  parameter int MAIN_W    = 12,
  parameter int AUX_W     = 14,
  parameter int MIN_RATIO = 16,
  parameter int B_DIV     = 4,
  parameter int C_DIV     = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  refRun_t           runCtl,
  input  logic [MAIN_W-1:0] mainRatio,
  input  logic [AUX_W-1:0]  auxRatio,
  output refTicks_t         ticks
);
  localparam int NumPost = 2;
  localparam int PostDiv [NumPost] = '{B_DIV, C_DIV};

  logic             tickA;
  logic             tickD;
  logic [NumPost-1:0] postTick;

  progDivider #(.WIDTH(MAIN_W), .MIN_RATIO(MIN_RATIO)) mainDiv_i (
    .clk(clk), .rstN(rstN), .run(runCtl.runMain), .ratio(mainRatio), .tick(tickA)
  );

  progDivider #(.WIDTH(AUX_W), .MIN_RATIO(MIN_RATIO)) auxDiv_i (
    .clk(clk), .rstN(rstN), .run(runCtl.runAux), .ratio(auxRatio), .tick(tickD)
  );

  for (genvar g = 0; g < NumPost; g++) begin : gPost
    fixedDivider #(.DIV(PostDiv[g])) post_i (
      .clk(clk), .rstN(rstN), .clear(!runCtl.runMain),
      .advance(tickA), .tick(postTick[g])
    );
  end

  always_comb begin
    ticks.tickA = tickA;
    ticks.tickB = postTick[0];
    ticks.tickC = postTick[1];
    ticks.tickD = tickD;
  end

  AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rstN)
    ticks.tickB |-> ticks.tickA); // R3
  AST_C_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rstN)
    ticks.tickC |-> ticks.tickA); // R4

endmodule

// File: rtl/refControl.sv
module refControl
  import refdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      auxEnable,
  input  logic [1:0] selCode,
  input  logic      refPowerDown,
  input  refTicks_t ticks,
  output refRun_t   runCtl,
  output logic      fr1Strobe,
  output logic      fr2Strobe
);
  fr1Sel_e sel;
  logic    fr1Next;
  logic    fr2Next;

  always_comb begin
    sel            = fr1Sel_e'(selCode);
    runCtl.runMain = !refPowerDown;
    runCtl.runAux  = !refPowerDown && auxEnable;
    unique case (sel)
      SEL_A:   fr1Next = ticks.tickA;
      SEL_B:   fr1Next = ticks.tickB;
      SEL_C:   fr1Next = auxEnable && ticks.tickC;
      default: fr1Next = 1'b0;
    endcase
    fr2Next = auxEnable ? ticks.tickD : ticks.tickC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fr1Strobe <= 1'b0;
      fr2Strobe <= 1'b0;
    end else begin
      fr1Strobe <= fr1Next;
      fr2Strobe <= fr2Next;
    end
  end

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    refPowerDown |=> (!fr1Strobe && !fr2Strobe)); // R8
  AST_SEL_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == 2'b00) |=> !fr1Strobe); // R5
  AST_SEL_C_NOAUX_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (selCode == 2'b11 && !auxEnable) |=> !fr1Strobe); // R5

endmodule

// File: rtl/clkOutDivider.sv
module clkOutDivider (
  input  logic clk,
  input  logic rstN,
  input  logic div4,
  output logic clkOut
);
  logic [1:0] cnt;
  logic [1:0] lastVal;
  logic [1:0] highLen;

  always_comb begin
    lastVal = div4 ? 2'd3 : 2'd2;
    highLen = div4 ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else begin
      cnt    <= (cnt >= lastVal) ? 2'd0 : cnt + 2'd1;
      clkOut <= (cnt < highLen);
    end
  end

  AST_DIV3_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (!div4 && $past(!div4) && $rose(clkOut)) |=> !clkOut); // R9

endmodule

// File: rtl/refDivRoute.sv
module refDivRoute
  import refdiv_pkg::*;
#(
  parameter int MAIN_W    = 12,
  parameter int AUX_W     = 14,
  parameter int MIN_RATIO = 16,
  parameter int B_DIV     = 4,
  parameter int C_DIV     = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAIN_W-1:0] mainRatio,
  input  logic [AUX_W-1:0]  auxRatio,
  input  logic              auxEnable,
  input  logic [1:0]        selCode,
  input  logic              refPowerDown,
  input  logic              clkOutDiv4,
  output logic              fr1Strobe,
  output logic              fr2Strobe,
  output logic              mcuClk
);
  refTicks_t ticks;
  refRun_t   runCtl;

  refDatapath #(
    .MAIN_W(MAIN_W), .AUX_W(AUX_W), .MIN_RATIO(MIN_RATIO),
    .B_DIV(B_DIV), .C_DIV(C_DIV)
  ) dp_i (
    .clk(clk), .rstN(rstN), .runCtl(runCtl),
    .mainRatio(mainRatio), .auxRatio(auxRatio), .ticks(ticks)
  );

  refControl ctl_i (
    .clk(clk), .rstN(rstN), .auxEnable(auxEnable), .selCode(selCode),
    .refPowerDown(refPowerDown), .ticks(ticks), .runCtl(runCtl),
    .fr1Strobe(fr1Strobe), .fr2Strobe(fr2Strobe)
  );

  clkOutDivider mcu_i (
    .clk(clk), .rstN(rstN), .div4(clkOutDiv4), .clkOut(mcuClk)
  );

endmodule

// File: tb/refDivRoute_tb.sv
module refDivRoute_tb_top;
  localparam time ClkPeriod = 10ns;
  localparam int  Watchdog  = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] mainRatio = 12'd20;
  logic [13:0] auxRatio = 14'd37;
  logic        auxEnable = 1'b0;
  logic [1:0]  selCode = 2'b01;
  logic        refPowerDown = 1'b0;
  logic        clkOutDiv4 = 1'b1;
  logic        fr1Strobe, fr2Strobe, mcuClk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  refDivRoute dut_i (
    .clk(clk), .rstN(rstN), .mainRatio(mainRatio), .auxRatio(auxRatio),
    .auxEnable(auxEnable), .selCode(selCode), .refPowerDown(refPowerDown),
    .clkOutDiv4(clkOutDiv4), .fr1Strobe(fr1Strobe), .fr2Strobe(fr2Strobe),
    .mcuClk(mcuClk)
  );

  always #(ClkPeriod/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == Watchdog) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cycles, Watchdog);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic pick(int which);
    case (which)
      0: return fr1Strobe;
      1: return fr2Strobe;
      default: return mcuClk;
    endcase
  endfunction

  function automatic int clampR(int r);
    return (r < 16) ? 16 : r;
  endfunction

  // expected fr1 period, 0 means it stays low
  function automatic int expFr1(int code, int n, bit aux);
    case (code)
      1: return clampR(n);
      2: return 4 * clampR(n);
      3: return aux ? 25 * clampR(n) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int expFr2(int n, int m, bit aux);
    return aux ? clampR(m) : 25 * clampR(n);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // rising edge to rising edge, sampled at falling clock edges
  task automatic measure(int which, int limit, output int period, output int width);
    logic prev, cur;
    bit inHigh;
    period = 0;
    width = 0;
    @(negedge clk);
    prev = pick(which);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      cur = pick(which);
      if (!prev && cur) begin
        width = 1;
        break;
      end
      prev = cur;
    end
    if (width == 0) return;
    inHigh = 1'b1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      period++;
      if (pick(which)) begin
        if (inHigh) width++;
        else break;
      end else inHigh = 1'b0;
    end
  endtask

  task automatic countHighs(int which, int len, output int highs);
    highs = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pick(which)) highs++;
    end
  endtask

  task automatic firstLatency(int which, int limit, output int k);
    k = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (pick(which)) break;
    end
  endtask

  task automatic settledPeriod(int which, int limit, output int p, output int w);
    int dp, dw;
    measure(which, limit, dp, dw);
    measure(which, limit, p, w);
  endtask

  initial begin
    int p, w, k, h, n, m, code;
    bit aux;
    void'($urandom(32'hC0FFEE));

    // R10 outputs low in reset
    repeat (4) @(negedge clk);
    check(!fr1Strobe && !fr2Strobe && !mcuClk, "R10", {fr1Strobe, fr2Strobe, mcuClk}, 0);
    rstN = 1'b1;
    firstLatency(0, 200, k);
    check(k == 20, "R1 first pulse after reset", k, 20);

    settledPeriod(0, 300, p, w);
    check(p == 20 && w == 1, "R1 period code01", p * 100 + w, 2001);

    selCode = 2'b10;
    settledPeriod(0, 400, p, w);
    check(p == 80, "R3 period code10", p, 80);

    auxEnable = 1'b0;
    auxRatio = 14'd5000;
    settledPeriod(1, 1200, p, w);
    check(p == 500 && w == 1, "R6 fr2 from C", p, 500);
    auxRatio = 14'd9;
    settledPeriod(1, 1200, p, w);
    check(p == 500, "R6 aux ratio ignored", p, 500);

    selCode = 2'b11;
    countHighs(0, 600, h);
    check(h == 0, "R5 code11 without aux", h, 0);
    selCode = 2'b00;
    countHighs(0, 600, h);
    check(h == 0, "R5 code00", h, 0);

    auxEnable = 1'b1;
    auxRatio = 14'd37;
    selCode = 2'b11;
    settledPeriod(0, 1200, p, w);
    check(p == 500, "R4 code11 with aux", p, 500);
    settledPeriod(1, 200, p, w);
    check(p == 37 && w == 1, "R7 fr2 from D", p, 37);

    // R2 clamping
    mainRatio = 12'd3;
    selCode = 2'b01;
    settledPeriod(0, 200, p, w);
    check(p == 16 && w == 1, "R2 main clamp", p, 16);
    auxRatio = 14'd0;
    settledPeriod(1, 200, p, w);
    check(p == 16 && w == 1, "R2 aux clamp", p, 16);

    // R8 power-down
    mainRatio = 12'd30;
    auxRatio = 14'd45;
    refPowerDown = 1'b1;
    countHighs(0, 300, h);
    check(h == 0, "R8 fr1 quiet", h, 0);
    countHighs(1, 300, h);
    check(h == 0, "R8 fr2 quiet", h, 0);
    refPowerDown = 1'b0;
    firstLatency(0, 200, k);
    check(k == 30, "R8 main restart latency", k, 30);
    refPowerDown = 1'b1;
    repeat (3) @(negedge clk);
    refPowerDown = 1'b0;
    firstLatency(1, 200, k);
    check(k == 45, "R8 aux restart latency", k, 45);

    // R9 output clock
    clkOutDiv4 = 1'b1;
    settledPeriod(2, 20, p, w);
    check(p == 4 && w == 2, "R9 div4", p * 100 + w, 402);
    clkOutDiv4 = 1'b0;
    settledPeriod(2, 20, p, w);
    check(p == 3 && w == 1, "R9 div3", p * 100 + w, 301);

    // random configurations
    for (int it = 0; it < 8; it++) begin
      n = 16 + int'($urandom % 100);
      m = 16 + int'($urandom % 300);
      aux = 1'($urandom % 2);
      code = 1 + int'($urandom % 3);
      mainRatio = 12'(n);
      auxRatio = 14'(m);
      auxEnable = aux;
      selCode = 2'(code);
      if (expFr1(code, n, aux) == 0) begin
        countHighs(0, 400, h);
        check(h == 0, "R5 random off", h, 0);
      end else begin
        settledPeriod(0, 3000, p, w);
        check(p == expFr1(code, n, aux), code == 1 ? "R1 random" : (code == 2 ? "R3 random" : "R4 random"),
              p, expFr1(code, n, aux));
      end
      settledPeriod(1, 3000, p, w);
      check(p == expFr2(n, m, aux), aux ? "R7 random" : "R6 random", p, expFr2(n, m, aux));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule